// File: doc/BRIEF.md
# Pixel Capture FIFO Slave

This block takes raw pixel samples from a parallel CMOS image sensor and places one frame of them in an on-chip first-in first-out buffer. A memory-mapped, read-only bus slave exposes that buffer to the rest of the system. A DMA engine, reading a fixed address again and again, empties the buffer at bus speed and learns where the frame stops from the endofpacket flag. No address generator is needed on the sensor side, and no frame store is kept on chip.

The sensor side runs on the sensor's pixel clock and follows its frame-valid and line-valid qualifiers. A one-cycle arm pulse from the bus domain prepares the block to take the next frame. Capture begins at the next rising edge of frame-valid and ends when frame-valid falls. Write and read pointers cross between the two clocks in Gray code through two-flop synchronizers. A second address returns the fill level, a sticky overflow flag and a busy flag.

Top module: `pixel_capture_slave`

## Requirements
- R1: After reset, a status read returns 0 and a data read returns 0 with endofpacket low.
- R2: During a captured frame, a pixel is stored on each rising pixel-clock edge where frame-valid and line-valid are both high. Pixels are returned in arrival order in readdata[7:0], with all upper bits zero. Line-valid pulses outside frame-valid are ignored.
- R3: Nothing is captured unless arm has been pulsed first. When arm arrives while frame-valid is already high, capture waits for the next rising edge of frame-valid.
- R4: Only one frame is captured per arm. Later frames are ignored until the block is armed again.
- R5: endofpacket is high on exactly the data read that returns the last pixel of the frame, including a frame of a single pixel.
- R6: A read at address 0 with chipselect, read and begintransfer all high pops one entry. A read cycle with begintransfer low does not pop. A read at address 1 does not pop.
- R7: A data read from an empty buffer returns 0, holds endofpacket low and pops nothing.
- R8: A status read (address 1) returns the fill level in bits [15:0], overflow in bit 16 and busy in bit 17, with the other bits zero. Once the clock crossings settle, the level equals the number of stored pixels, up to the full depth.
- R9: A pixel that must be written while the buffer is full is dropped, and the overflow bit is set. Entries already stored are kept. The overflow bit stays set until the next arm clears it.
- R10: The busy bit rises after arm and falls after the captured frame's frame-valid drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous in both clock domains |
| chipselect | input | 1 | Slave select |
| address | input | 1 | 0 = pixel data, 1 = status |
| read | input | 1 | Read strobe |
| begintransfer | input | 1 | High in the first cycle of each transfer |
| readdata | output | 32 | Data or status word |
| endofpacket | output | 1 | Marks the frame's last pixel on a data read |
| arm | input | 1 | One-cycle pulse (bus clock) that arms capture of one frame |
| pclk | input | 1 | Sensor pixel clock |
| fvalid | input | 1 | Frame-valid from the sensor |
| lvalid | input | 1 | Line-valid from the sensor |
| pixel | input | 8 | Raw sample from the sensor |

## Verification
A bad write or read pointer shows up as a wrong fill level on the first status read after the crossing settles, within a few cycles. It also shows up as a pixel out of order on the next data read. A lost or misplaced end marker moves endofpacket away from the frame's last pixel, so a full drain of every frame exposes it. A frame-state machine that starts or stops at the wrong edge stores pixels from an unarmed frame, or misses an armed one; the level read right after that frame shows the error. A non-sticky or uncleared overflow flag is caught by status reads made after the burst that overflows and after re-arming. The bench uses a 16-entry buffer so that full and overflow conditions are reached.

// File: rtl/cap_pkg.sv
// Shared types for the pixel capture slave.
package cap_pkg;
    // Sensor-side capture state
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2
    } cap_state_e;

    localparam logic ADR_DATA   = 1'b0;
    localparam logic ADR_STATUS = 1'b1;
    localparam int   STAT_OVF   = 16;
    localparam int   STAT_BUSY  = 17;
endpackage

// File: rtl/cap_fifo_ram.sv
// Buffer storage: written on the pixel clock, read asynchronously from the bus side.
// Assumes the reader only addresses entries the pointer protocol marks as written.
module cap_fifo_ram #(
    parameter int AW = 11,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one entry per write strobe
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cap_ptr_sync.sv
// Two-flop synchronizer for a Gray-coded pointer, with a Gray-to-binary decoder after it.
// Assumes the source changes the pointer by at most one step per source clock.
module cap_ptr_sync #(
    parameter int W = 12
) (
    input  logic         dclk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1, s2;

    // Two-stage resynchronisation into the destination clock
    always_ff @(posedge dclk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= gray_in;
            s2 <= s1;
        end
    end

    // Gray to binary: each bit is the parity of the bits above and including it
    always_comb begin
        for (int i = 0; i < W; i++) bin_out[i] = ^(s2 >> i);
    end
endmodule

// File: rtl/cap_sensor_side.sv
// Pixel-clock half of the capture path: arm handshake, frame state, one-pixel staging
// register that tags the frame's last pixel, write pointer and sticky overflow.
// Assumes arm_tgl comes from the bus clock and rd_bin_s is already synchronized.
module cap_sensor_side
    import cap_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int AW    = 11
) (
    input  logic             pclk,
    input  logic             rst_n,
    input  logic             fvalid,
    input  logic             lvalid,
    input  logic [PIX_W-1:0] pixel,
    input  logic             arm_tgl,
    input  logic [AW:0]      rd_bin_s,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [PIX_W:0]   wr_word,
    output logic [AW:0]      wr_gray,
    output logic             ovf,
    output logic             busy
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);

    cap_state_e       state, state_d;
    logic [2:0]       arm_sync;
    logic             fv_q;
    logic             stg_vld;
    logic [PIX_W-1:0] stg_data;
    logic [PW-1:0]    wr_ptr, wr_ptr_d, level_w;
    logic             arm_req, fv_rise, take, frame_end, wr_req, full;

    // Bring the arm toggle into the pixel clock and keep the prior sample for edge detection
    always_ff @(posedge pclk) begin
        if (!rst_n) arm_sync <= '0;
        else        arm_sync <= {arm_sync[1:0], arm_tgl};
    end

    assign arm_req   = arm_sync[2] ^ arm_sync[1];
    assign fv_rise   = fvalid && !fv_q;
    assign take      = lvalid && ((state == CAP_RUN && fvalid) || (state == CAP_ARMED && fv_rise));
    assign frame_end = (state == CAP_RUN) && !fvalid;
    assign wr_req    = stg_vld && (take || frame_end);
    assign level_w   = wr_ptr - rd_bin_s;
    assign full      = (level_w == DEPTH_V);
    assign wr_en     = wr_req && !full;
    assign wr_addr   = wr_ptr[AW-1:0];
    assign wr_word   = {frame_end, stg_data};
    assign wr_ptr_d  = wr_ptr + PW'(wr_en);
    assign busy      = (state != CAP_IDLE);

    // Next capture state: idle -> armed on request, armed -> run on frame start, run -> idle on frame end
    always_comb begin
        state_d = state;
        case (state)
            CAP_IDLE:  if (arm_req) state_d = CAP_ARMED;
            CAP_ARMED: if (fv_rise) state_d = CAP_RUN;
            CAP_RUN:   if (!fvalid) state_d = CAP_IDLE;
            default:   state_d = CAP_IDLE;
        endcase
    end

    // State, frame-valid history, staging register, pointer and overflow flag
    always_ff @(posedge pclk) begin
        if (!rst_n) begin
            state    <= CAP_IDLE;
            fv_q     <= 1'b0;
            stg_vld  <= 1'b0;
            stg_data <= '0;
            wr_ptr   <= '0;
            wr_gray  <= '0;
            ovf      <= 1'b0;
        end else begin
            state   <= state_d;
            fv_q    <= fvalid;
            wr_ptr  <= wr_ptr_d;
            wr_gray <= wr_ptr_d ^ (wr_ptr_d >> 1);
            if (take) begin
                stg_vld  <= 1'b1;
                stg_data <= pixel;
            end else if (frame_end) begin
                stg_vld  <= 1'b0;
            end
            if (state == CAP_IDLE && arm_req) ovf <= 1'b0;
            else if (wr_req && full)          ovf <= 1'b1;
        end
    end

    // R9
    level_bound_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        level_w <= DEPTH_V);
    // R9
    ovf_sticky_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        (ovf && !(state == CAP_IDLE && arm_req)) |=> ovf);
    // R4
    frame_stop_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        (state == CAP_RUN && !fvalid) |=> (state == CAP_IDLE));
    // R8
    wr_gray_step_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/pixel_capture_slave.sv
// Top level: bus-clock read slave over the capture buffer. Data reads pop the head
// and carry the end-of-frame tag; status reads return level, overflow and busy.
// Assumes rst_n is held long enough to be seen by both clocks.
module pixel_capture_slave
    import cap_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int AW    = 11,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chipselect,
    input  logic             address,
    input  logic             read,
    input  logic             begintransfer,
    output logic [BUS_W-1:0] readdata,
    output logic             endofpacket,
    input  logic             arm,
    input  logic             pclk,
    input  logic             fvalid,
    input  logic             lvalid,
    input  logic [PIX_W-1:0] pixel
);
    localparam int PW = AW + 1;

    logic             arm_tgl;
    logic [PW-1:0]    rd_ptr, rd_ptr_d, rd_gray, rd_bin_s, wr_gray, wr_bin_s, level;
    logic             wr_en, ovf_p, busy_p, empty, data_hit, pop;
    logic [AW-1:0]    wr_addr;
    logic [PIX_W:0]   wr_word, head;
    logic [1:0]       ovf_s, busy_s;

    cap_sensor_side #(.PIX_W(PIX_W), .AW(AW)) u_sensor (
        .pclk    (pclk),
        .rst_n   (rst_n),
        .fvalid  (fvalid),
        .lvalid  (lvalid),
        .pixel   (pixel),
        .arm_tgl (arm_tgl),
        .rd_bin_s(rd_bin_s),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word (wr_word),
        .wr_gray (wr_gray),
        .ovf     (ovf_p),
        .busy    (busy_p)
    );

    cap_fifo_ram #(.AW(AW), .DW(PIX_W + 1)) u_ram (
        .wclk (pclk),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_word),
        .raddr(rd_ptr[AW-1:0]),
        .rdata(head)
    );

    cap_ptr_sync #(.W(PW)) u_wr_sync (
        .dclk   (clk),
        .rst_n  (rst_n),
        .gray_in(wr_gray),
        .bin_out(wr_bin_s)
    );

    cap_ptr_sync #(.W(PW)) u_rd_sync (
        .dclk   (pclk),
        .rst_n  (rst_n),
        .gray_in(rd_gray),
        .bin_out(rd_bin_s)
    );

    assign empty    = (wr_bin_s == rd_ptr);
    assign level    = wr_bin_s - rd_ptr;
    assign data_hit = chipselect && read && (address == ADR_DATA);
    assign pop      = data_hit && begintransfer && !empty;
    assign rd_ptr_d = rd_ptr + PW'(pop);

    // Arm toggle, read pointer with its Gray copy, and status-bit synchronizers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_tgl <= 1'b0;
            rd_ptr  <= '0;
            rd_gray <= '0;
            ovf_s   <= '0;
            busy_s  <= '0;
        end else begin
            arm_tgl <= arm_tgl ^ arm;
            rd_ptr  <= rd_ptr_d;
            rd_gray <= rd_ptr_d ^ (rd_ptr_d >> 1);
            ovf_s   <= {ovf_s[0], ovf_p};
            busy_s  <= {busy_s[0], busy_p};
        end
    end

    // Select the data or status word for the current read
    always_comb begin
        readdata = '0;
        if (address == ADR_STATUS) begin
            readdata[PW-1:0]  = level;
            readdata[STAT_OVF]  = ovf_s[1];
            readdata[STAT_BUSY] = busy_s[1];
        end else if (!empty) begin
            readdata[PIX_W-1:0] = head[PIX_W-1:0];
        end
    end

    assign endofpacket = data_hit && !empty && head[PIX_W];

    // R7
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> (rd_ptr == $past(rd_ptr)));
    // R5
    eop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        endofpacket |-> (address == ADR_DATA && level != '0));
    // R8
    rd_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: tb/tb_pixel_capture_slave.sv
module tb_pixel_capture_slave;
    localparam int CLK_PERIOD  = 10;
    localparam int PCLK_PERIOD = 26;
    localparam int AW          = 4;
    localparam int DEPTH       = 1 << AW;

    logic        clk = 0, pclk = 0, rst_n = 0;
    logic        chipselect = 0, address = 0, read = 0, begintransfer = 0, arm = 0;
    logic        fvalid = 0, lvalid = 0;
    logic [7:0]  pixel = 0;
    logic [31:0] readdata;
    logic        endofpacket;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2)  clk  = ~clk;
    always #(PCLK_PERIOD/2) pclk = ~pclk;

    pixel_capture_slave #(.PIX_W(8), .AW(AW), .BUS_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .chipselect(chipselect), .address(address),
        .read(read), .begintransfer(begintransfer), .readdata(readdata),
        .endofpacket(endofpacket), .arm(arm), .pclk(pclk), .fvalid(fvalid),
        .lvalid(lvalid), .pixel(pixel)
    );

    function automatic logic [7:0] pv(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] stat(int lvl, bit ovf, bit busy);
        return {14'd0, busy, ovf, 16'(lvl)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic bus_read(input logic a, input logic bt, output logic [31:0] d, output logic e);
        @(negedge clk);
        chipselect = 1; read = 1; address = a; begintransfer = bt;
        #1;
        d = readdata; e = endofpacket;
        @(posedge clk); #1;
        chipselect = 0; read = 0; begintransfer = 0;
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1;
        @(negedge clk); arm = 0;
        repeat (6) @(negedge pclk);
    endtask

    task automatic settle();
        repeat (5) @(negedge pclk);
        repeat (5) @(negedge clk);
    endtask

    task automatic pclk_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge pclk); lvalid = 0; pixel = 8'h55;
        end
    endtask

    // One line of n pixels starting at sequence index idx
    task automatic send_line(int n, inout int idx);
        for (int i = 0; i < n; i++) begin
            @(negedge pclk); lvalid = 1; pixel = pv(idx); idx++;
        end
        pclk_idle(2);
    endtask

    task automatic send_frame(int lines, int ppl, int seed);
        int idx = seed;
        // stray line-valid outside the frame must be ignored (R2)
        @(negedge pclk); lvalid = 1; pixel = 8'hEE;
        @(negedge pclk); lvalid = 1; pixel = 8'hEF;
        pclk_idle(1);
        @(negedge pclk); fvalid = 1;
        pclk_idle(2);
        for (int l = 0; l < lines; l++) send_line(ppl, idx);
        @(negedge pclk); fvalid = 0;
        pclk_idle(2);
    endtask

    task automatic drain(string req, int n, int seed, bit eop_last);
        logic [31:0] d; logic e;
        for (int i = 0; i < n; i++) begin
            bus_read(1'b0, 1'b1, d, e);
            check(req, d, {24'd0, pv(seed + i)});
            check("R5", {31'd0, e}, {31'd0, eop_last && (i == n - 1)});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d; logic e;
        repeat (6) @(negedge pclk);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R1 reset state
        bus_read(1'b1, 1'b1, d, e);
        check("R1", d, 32'd0);
        bus_read(1'b0, 1'b1, d, e);
        check("R1", d, 32'd0);
        check("R7", {31'd0, e}, 32'd0);

        // R3 frame without arm is ignored
        send_frame(2, 3, 0);
        settle();
        bus_read(1'b1, 1'b1, d, e);
        check("R3", d, stat(0, 0, 0));

        // R10 busy after arm; R2 multi-line frame with gaps
        pulse_arm();
        settle();
        bus_read(1'b1, 1'b1, d, e);
        check("R10", d, stat(0, 0, 1));
        send_frame(3, 4, 100);
        settle();
        bus_read(1'b1, 1'b1, d, e);
        check("R8", d, stat(12, 0, 0));
        drain("R2", 12, 100, 1);
        // R7 empty read
        bus_read(1'b0, 1'b1, d, e);
        check("R7", d, 32'd0);
        check("R7", {31'd0, e}, 32'd0);
        bus_read(1'b1, 1'b1, d, e);
        check("R7", d, stat(0, 0, 0));

        // R4 a second frame without re-arm is ignored
        send_frame(1, 5, 7);
        settle();
        bus_read(1'b1, 1'b1, d, e);
        check("R4", d, stat(0, 0, 0));

        // R6 pop rules
        pulse_arm();
        send_frame(1, 5, 200);
        settle();
        bus_read(1'b1, 1'b1, d, e);
        bus_read(1'b1, 1'b1, d, e);
        check("R6", d, stat(5, 0, 0));
        bus_read(1'b0, 1'b0, d, e);
        check("R6", d, {24'd0, pv(200)});
        bus_read(1'b1, 1'b1, d, e);
        check("R6", d, stat(5, 0, 0));
        drain("R6", 5, 200, 1);

        // R3 arm while frame-valid is high waits for the next frame
        @(negedge pclk); fvalid = 1;
        begin
            int idx = 50;
            send_line(3, idx);
            pulse_arm();
            send_line(3, idx);
        end
        @(negedge pclk); fvalid = 0;
        settle();
        bus_read(1'b1, 1'b1, d, e);
        check("R3", d, stat(0, 0, 1));
        send_frame(2, 2, 300);
        settle();
        bus_read(1'b1, 1'b1, d, e);
        check("R3", d, stat(4, 0, 0));
        drain("R3", 4, 300, 1);

        // R9 overflow: 20 pixels into 16 entries
        pulse_arm();
        send_frame(1, DEPTH + 4, 400);
        settle();
        bus_read(1'b1, 1'b1, d, e);
        check("R9", d, stat(DEPTH, 1, 0));
        drain("R9", DEPTH, 400, 0);
        bus_read(1'b1, 1'b1, d, e);
        check("R9", d, stat(0, 1, 0));
        pulse_arm();
        settle();
        bus_read(1'b1, 1'b1, d, e);
        check("R9", d, stat(0, 0, 1));

        // R5 single-pixel frame carries the end marker
        send_frame(1, 1, 500);
        settle();
        bus_read(1'b1, 1'b1, d, e);
        check("R5", d, stat(1, 0, 0));
        drain("R5", 1, 500, 1);

        finish_run();
    end
endmodule